// File: doc/BRIEF.md
# Single-Channel Bus-Hold Block Mover

This block copies a block of bytes between system memory and one peripheral port without the processor taking part. Software first loads a start address, a byte count and a control word through a small register port. When the peripheral raises its service request, the mover asks the processor for the shared buses with a hold request. It waits for the processor's acknowledge, then tells the peripheral that service has begun. It moves the block one byte at a time. Each byte takes a read strobe on the source side, then a write strobe on the destination side, with the current address on the address bus. The data bus is shared directly between memory and the port, so the mover never holds the data itself.

The direction is set in the control word. One setting moves bytes from memory to the port. The other moves bytes from the port to memory. After the final byte the mover releases the buses, clears its enable, flags completion in its status word and can raise a one-cycle interrupt. If the peripheral withdraws its request partway through, the mover finishes the byte in progress, returns the buses and keeps its position, so the block resumes when the request comes back.

Top module: `bushold_dma`

## Requirements
- R1: After reset, hold, dack, bus_oe, all four strobes and irq are low, bus_addr is zero, and the address, count, control and status registers read zero.
- R2: While idle with control bit 0 (enable) set and dreq high, hold rises. With enable clear, dreq leaves hold low.
- R3: bus_oe, dack and the strobes stay low until hlda has been seen high while hold is raised. hold then stays high until the block ends or the mover pauses.
- R4: dack and bus_oe are high exactly while the mover owns the buses, and bus_addr shows the address register at those times.
- R5: Each byte is one read-strobe cycle, one idle cycle, then one write-strobe cycle, both at the same address. No two strobes are ever active together, and a strobe is never followed directly by another strobe.
- R6: With control bit 1 clear, the byte is moved by mem_rd and then io_wr. With control bit 1 set, it is moved by io_rd and then mem_wr.
- R7: After each byte the address increments by one, wrapping at the top of its range. The count decrements by one. A count of N-1 moves exactly N bytes and reads zero when the block ends.
- R8: At block end hold falls, control bit 0 clears, and status bit 1 (terminal count) sets. If control bit 2 is set, irq is high for exactly one cycle.
- R9: If dreq is low when a byte completes, the mover drops dack and hold, keeps the address and count, and resumes from there when dreq returns.
- R10: Register writes while hold is high are ignored. Status bit 0 (busy) reads 1 exactly while hold is high.
- R11: reg_sel selects the register: 0 is address, 1 is count, 2 is control, 3 is status (read-only). reg_rdata shows the selected register in the same cycle. A control write clears the terminal-count bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Selected register contents |
| dreq | input | 1 | Peripheral service request |
| dack | output | 1 | Service acknowledge to peripheral |
| hold | output | 1 | Bus request to processor |
| hlda | input | 1 | Bus grant from processor |
| bus_oe | output | 1 | Mover drives address and strobes |
| bus_addr | output | ADDR_W | Address bus |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| irq | output | 1 | Block-complete pulse |

## Verification
A per-cycle model predicts the next strobe and the address it must carry. It tracks the byte count and flags any bus activity seen before the grant. The model is run against four patterns.

A four-byte memory-to-port block with an immediate grant exercises the basic strobe order and the completion pulse. A one-byte port-to-memory block starts at the top address and gets a delayed grant. It separates the two directions, shows the address wrap, and shows that nothing is driven while waiting for the grant. An eight-byte block has its request withdrawn after three bytes. It shows that the position survives a pause. A block hit by register writes while running shows those writes have no effect on the strobed addresses or the byte total.

// File: rtl/bhdma_pkg.sv
package bhdma_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_GRANT,
        PH_RD,
        PH_GAP,
        PH_WR,
        PH_NEXT
    } phase_t;

    // control word: bit2 interrupt enable, bit1 port-to-memory, bit0 enable
    typedef struct packed {
        logic irq_en;
        logic to_mem;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } strobe_t;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    function automatic strobe_t strobe_for(phase_t ph, logic to_mem);
        strobe_t s;
        s = '0;
        if (ph == PH_RD) begin
            s.mem_rd = !to_mem;
            s.io_rd  = to_mem;
        end
        if (ph == PH_WR) begin
            s.io_wr  = !to_mem;
            s.mem_wr = to_mem;
        end
        return s;
    endfunction

    function automatic logic owns_bus(phase_t ph);
        return (ph == PH_GRANT) || (ph == PH_RD) || (ph == PH_GAP) ||
               (ph == PH_WR) || (ph == PH_NEXT);
    endfunction

endpackage

// File: rtl/bhdma_regs.sv
module bhdma_regs
    import bhdma_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              busy,
    input  logic              step,
    input  logic              done,
    output logic [ADDR_W-1:0] addr_q,
    output logic              cnt_zero,
    output ctrl_t             ctrl_q,
    output logic              irq
);

    logic [CNT_W-1:0] cnt_q;
    logic             tc_q;

    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
            tc_q   <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (we && !busy) begin
                case (sel)
                    SEL_ADDR: addr_q <= ADDR_W'(wdata);
                    SEL_CNT:  cnt_q  <= CNT_W'(wdata);
                    SEL_CTRL: begin
                        ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
                        tc_q   <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (step) begin
                addr_q <= addr_q + 1'b1;
                if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
            end
            if (done) begin
                ctrl_q.run <= 1'b0;
                tc_q       <= 1'b1;
                irq        <= ctrl_q.irq_en;
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_ADDR: rdata = REG_W'(addr_q);
            SEL_CNT:  rdata = REG_W'(cnt_q);
            SEL_CTRL: rdata = REG_W'(ctrl_q);
            default:  rdata = REG_W'({tc_q, busy});
        endcase
    end

endmodule

// File: rtl/bhdma_seq.sv
module bhdma_seq
    import bhdma_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ctrl_t   ctrl,
    input  logic    dreq,
    input  logic    hlda,
    input  logic    cnt_zero,
    output logic    hold,
    output logic    own,
    output logic    step,
    output logic    done,
    output strobe_t strb
);

    phase_t ph, nx;
    logic   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            last_q <= 1'b0;
        end else begin
            ph <= nx;
            if (ph == PH_WR) last_q <= cnt_zero;
        end
    end

    always_comb begin
        nx = ph;
        case (ph)
            PH_IDLE:  if (ctrl.run && dreq) nx = PH_REQ;
            PH_REQ:   if (hlda) nx = PH_GRANT;
            PH_GRANT: nx = PH_RD;
            PH_RD:    nx = PH_GAP;
            PH_GAP:   nx = PH_WR;
            PH_WR:    nx = PH_NEXT;
            PH_NEXT: begin
                if (last_q)    nx = PH_IDLE;
                else if (dreq) nx = PH_RD;
                else           nx = PH_IDLE;
            end
            default:  nx = PH_IDLE;
        endcase
    end

    assign hold = (ph != PH_IDLE);
    assign own  = owns_bus(ph);
    assign step = (ph == PH_WR);
    assign done = (ph == PH_NEXT) && last_q;
    assign strb = strobe_for(ph, ctrl.to_mem);

endmodule

// File: rtl/bushold_dma.sv
module bushold_dma
    import bhdma_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              dreq,
    output logic              dack,
    output logic              hold,
    input  logic              hlda,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              irq
);

    logic [ADDR_W-1:0] addr_q;
    logic              cnt_zero;
    ctrl_t             ctrl_q;
    logic              own;
    logic              step;
    logic              done;
    strobe_t           strb;

    bhdma_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (hold),
        .step     (step),
        .done     (done),
        .addr_q   (addr_q),
        .cnt_zero (cnt_zero),
        .ctrl_q   (ctrl_q),
        .irq      (irq)
    );

    bhdma_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_q),
        .dreq     (dreq),
        .hlda     (hlda),
        .cnt_zero (cnt_zero),
        .hold     (hold),
        .own      (own),
        .step     (step),
        .done     (done),
        .strb     (strb)
    );

    assign dack     = own;
    assign bus_oe   = own;
    assign bus_addr = own ? addr_q : '0;
    assign mem_rd   = strb.mem_rd;
    assign mem_wr   = strb.mem_wr;
    assign io_rd    = strb.io_rd;
    assign io_wr    = strb.io_wr;

endmodule

// File: rtl/bhdma_chk.sv
module bhdma_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              hold,
    input logic              hlda,
    input logic              dack,
    input logic              bus_oe,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              irq,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [ADDR_W-1:0] addr_q,
    input logic [2:0]        ctrl_bits
);

    logic any_strb;
    assign any_strb = mem_rd | mem_wr | io_rd | io_wr;

    assert_no_early_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(hlda));

    assert_own_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_oe || dack || any_strb) |-> (hold && dack && bus_oe));

    assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1);

    assert_gap_R5: assert property (@(posedge clk) disable iff (rst)
        any_strb |=> !any_strb);

    assert_dir_fwd_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || io_wr) |-> !ctrl_bits[1]);

    assert_dir_rev_R6: assert property (@(posedge clk) disable iff (rst)
        (io_rd || mem_wr) |-> ctrl_bits[1]);

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_wr || io_wr) |=> (addr_q == $past(addr_q) + 1'b1));

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        (hold && reg_we && reg_sel == 2'd0) |=>
            (addr_q == $past(addr_q) + ADDR_W'($past(mem_wr || io_wr))));

endmodule

bind bushold_dma bhdma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .hlda      (hlda),
    .dack      (dack),
    .bus_oe    (bus_oe),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .irq       (irq),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .addr_q    (addr_q),
    .ctrl_bits (ctrl_q)
);

// File: tb/sim_bushold_dma.sv
`timescale 1ns/1ps
module sim_bushold_dma;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dreq = 1'b0;
    logic        dack, hold, bus_oe;
    logic        hlda = 1'b0;
    logic [15:0] bus_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr, irq;

    always #4 clk = ~clk;

    bushold_dma u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .dack(dack), .hold(hold), .hlda(hlda), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // processor model: grants after a programmable delay
    int hlda_delay = 0;
    initial begin
        int k = 0;
        forever begin
            @(posedge clk);
            if (hold) k++; else k = 0;
            hlda <= hold && (k > hlda_delay);
        end
    end

    // reference model of the byte stream, compared every clock
    logic [15:0] exp_addr = '0;
    bit          exp_to_mem = 1'b0;
    int          bytes_seen = 0;
    int          irq_seen = 0;
    bit          pend_rd = 1'b0;
    bit          prev_strb = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                bit s;
                s = mem_rd | mem_wr | io_rd | io_wr;
                if (bus_oe && !hlda) chk(0, "R3 drive before grant", 1, 0);
                if (dack != bus_oe) chk(0, "R4 dack/oe", dack, bus_oe);
                if (bus_oe && !hold) chk(0, "R3 hold during ownership", 0, 1);
                if ((mem_rd + mem_wr + io_rd + io_wr) > 1) chk(0, "R5 overlap", 1, 0);
                if (s && prev_strb) chk(0, "R5 gap", 1, 0);
                if (mem_rd || io_rd) begin
                    chk(io_rd == exp_to_mem, "R6 read side", io_rd, exp_to_mem);
                    chk(bus_addr == exp_addr, "R5 read addr", bus_addr, exp_addr);
                    chk(!pend_rd, "R5 read twice", pend_rd, 0);
                    pend_rd = 1'b1;
                end
                if (mem_wr || io_wr) begin
                    chk(mem_wr == exp_to_mem, "R6 write side", mem_wr, exp_to_mem);
                    chk(bus_addr == exp_addr, "R5 write addr", bus_addr, exp_addr);
                    chk(pend_rd, "R5 write without read", 0, 1);
                    pend_rd = 1'b0;
                    exp_addr = exp_addr + 16'd1;
                    bytes_seen++;
                end
                if (irq) irq_seen++;
                prev_strb = s;
            end
        end
    end

    task automatic wr_reg(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [15:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wait_hold(input bit lvl, input int lim, input string req);
        int i;
        for (i = 0; i < lim; i++) begin
            @(negedge clk);
            #2;
            if (hold == lvl) break;
        end
        chk(hold == lvl, req, hold, lvl);
    endtask

    task automatic arm(input logic [15:0] a, input logic [15:0] c,
                       input logic [15:0] ctl);
        wr_reg(2'd0, a);
        wr_reg(2'd1, c);
        wr_reg(2'd2, ctl);
        exp_addr = a;
        exp_to_mem = ctl[1];
        bytes_seen = 0;
        irq_seen = 0;
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        chk({hold, dack, bus_oe, mem_rd, mem_wr, io_rd, io_wr, irq} == 0, "R1 outputs", hold, 0);
        chk(bus_addr == 0, "R1 bus_addr", bus_addr, 0);
        for (int s = 0; s < 4; s++) begin
            rd_reg(2'(s), v);
            chk(v == 0, "R1 R11 register", v, 0);
        end

        // R2: request without enable is ignored
        dreq = 1'b1;
        repeat (10) @(negedge clk);
        chk(hold == 0, "R2 no enable", hold, 0);
        dreq = 1'b0;

        // memory to port, 4 bytes, interrupt on
        arm(16'h1000, 16'd3, 16'b101);
        rd_reg(2'd0, v); chk(v == 16'h1000, "R11 addr readback", v, 16'h1000);
        rd_reg(2'd2, v); chk(v == 16'h5, "R11 ctrl readback", v, 16'h5);
        dreq = 1'b1;
        wait_hold(1, 20, "R2 hold rises");
        rd_reg(2'd3, v); chk(v == 16'h1, "R10 busy", v, 1);
        wait_hold(0, 200, "R8 hold falls");
        dreq = 1'b0;
        repeat (3) @(negedge clk);
        chk(bytes_seen == 4, "R7 byte total", bytes_seen, 4);
        chk(irq_seen == 1, "R8 irq pulse", irq_seen, 1);
        rd_reg(2'd3, v); chk(v == 16'h2, "R8 status tc", v, 2);
        rd_reg(2'd2, v); chk(v == 16'h4, "R8 enable cleared", v, 4);
        rd_reg(2'd0, v); chk(v == 16'h1004, "R7 final addr", v, 16'h1004);
        rd_reg(2'd1, v); chk(v == 16'h0, "R7 final count", v, 0);
        // R11: control write clears terminal count
        wr_reg(2'd2, 16'h0);
        rd_reg(2'd3, v); chk(v == 16'h0, "R11 tc cleared", v, 0);

        // port to memory, 1 byte, wrap, delayed grant, no interrupt
        hlda_delay = 5;
        arm(16'hFFFF, 16'd0, 16'b011);
        dreq = 1'b1;
        wait_hold(1, 20, "R2 hold rises");
        repeat (4) @(negedge clk);
        chk(bus_oe == 0 && dack == 0, "R3 wait for grant", bus_oe, 0);
        wait_hold(0, 200, "R8 hold falls");
        dreq = 1'b0;
        repeat (3) @(negedge clk);
        chk(bytes_seen == 1, "R6 R7 single byte", bytes_seen, 1);
        chk(irq_seen == 0, "R8 irq disabled", irq_seen, 0);
        rd_reg(2'd0, v); chk(v == 16'h0000, "R7 addr wrap", v, 0);
        hlda_delay = 0;

        // pause and resume, 8 bytes
        arm(16'h0200, 16'd7, 16'b001);
        dreq = 1'b1;
        for (int i = 0; i < 200 && bytes_seen < 3; i++) begin
            @(negedge clk);
            #2;
        end
        dreq = 1'b0;
        wait_hold(0, 20, "R9 release on pause");
        chk(bytes_seen == 3, "R9 bytes before pause", bytes_seen, 3);
        repeat (10) @(negedge clk);
        chk(hold == 0, "R9 stays released", hold, 0);
        rd_reg(2'd0, v); chk(v == 16'h0203, "R9 addr kept", v, 16'h0203);
        rd_reg(2'd1, v); chk(v == 16'd4, "R9 count kept", v, 4);
        dreq = 1'b1;
        wait_hold(1, 20, "R9 resume");
        wait_hold(0, 200, "R8 hold falls");
        dreq = 1'b0;
        repeat (2) @(negedge clk);
        chk(bytes_seen == 8, "R9 total after resume", bytes_seen, 8);
        rd_reg(2'd0, v); chk(v == 16'h0208, "R9 final addr", v, 16'h0208);

        // writes while busy are ignored
        arm(16'h0300, 16'd5, 16'b101);
        dreq = 1'b1;
        wait_hold(1, 20, "R2 hold rises");
        wr_reg(2'd2, 16'h0);
        wr_reg(2'd0, 16'h7777);
        wr_reg(2'd1, 16'h0001);
        wait_hold(0, 200, "R8 hold falls");
        dreq = 1'b0;
        repeat (3) @(negedge clk);
        chk(bytes_seen == 6, "R10 total unaffected", bytes_seen, 6);
        chk(irq_seen == 1, "R10 irq kept", irq_seen, 1);
        rd_reg(2'd0, v); chk(v == 16'h0306, "R10 addr unaffected", v, 16'h0306);

        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            chk(0, "watchdog", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule